// File: doc/BRIEF.md
# Port Pin-Change Interrupt Detector

This block watches a parallel bank of general-purpose pins and raises a sticky change flag when any pin that software has armed differs from a reference copy of the port. The reference copy is taken on every port access, whether read or write, rather than on every clock. A change therefore stays visible until software touches the port, even if the pin later returns to its old level. The flag also drives a wake request, so a pin change can bring the device out of a low-power state.

Pins come in asynchronously and pass through a synchronizer before they are compared. The arming mask is a per-pin register written through a simple write strobe. Software clears the flag with a clear strobe. A clear only takes effect once a port access has removed the mismatch, because a live mismatch keeps setting the flag. Two resets act on the block. The power-on reset clears everything and captures the reference copy from the pins. The warm reset clears only the flag and leaves the reference copy and the arming mask as they were. Only the single flag leaves the block, so software cannot tell which armed pin moved.

Top module: `ioc_detect`

## Requirements
- R1: While and after power-on reset (`rst_ni` low), `flag_o` is 0 and every arming bit is 0, so pin changes leave `flag_o` at 0 until a mask is written.
- R2: After power-on reset, the reference copy is loaded from the synchronized pins, so arming pins that have not moved since reset does not set `flag_o`.
- R3: If an armed pin differs from its reference bit, `flag_o` is set. It reads 1 after the third rising edge following the pin change and is still 0 after the second.
- R4: A pin whose arming bit is 0 never sets `flag_o`, whatever its level.
- R5: A cycle with `port_acc_i` high reloads the reference copy from the synchronized pins. This ends the mismatch, so a later clear leaves `flag_o` at 0.
- R6: `flag_o` is sticky. It stays 1 after the mismatch has ended until a clear or a reset.
- R7: When `flag_clr_i` coincides with a live mismatch, the set wins and `flag_o` stays 1.
- R8: A pin change whose synchronized value arrives in the same cycle as a port access still sets `flag_o`, even though the reference copy takes the new value on that edge.
- R9: A warm reset (`warm_rst_i` high) clears `flag_o` on that edge and keeps the reference copy and the arming mask. If a mismatch remains, `flag_o` is 1 again one edge later.
- R10: `wake_o` equals `flag_o` in every cycle.
- R11: `en_we_i` high loads `en_wdata_i` into the arming mask on that edge. Bit i arms pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst_i | input | 1 | Warm reset, synchronous, active high |
| pins_i | input | WIDTH | Asynchronous pin levels |
| port_acc_i | input | 1 | Port read or write access strobe |
| en_we_i | input | 1 | Arming mask write strobe |
| en_wdata_i | input | WIDTH | Arming mask write data |
| flag_clr_i | input | 1 | Flag clear strobe |
| flag_o | output | 1 | Sticky change flag |
| wake_o | output | 1 | Wake request |

## Verification
A pin change reaches `flag_o` on the third rising edge: two synchronizer stages, then the flag register. The bench therefore checks that the flag is still low after two edges and high after three. Strobes such as the clear, the access and the warm reset act on the next edge, so their effect is sampled one cycle after they are applied. The coincidence case raises the access strobe exactly in the cycle after the second synchronizer edge. All inputs are driven and all outputs sampled mid-cycle. An exhaustive sweep over every arming mask and every single-pin toggle compares the flag with the mask bit of the toggled pin.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  localparam int unsigned DEF_WIDTH  = 8;
  localparam int unsigned DEF_STAGES = 2;

  typedef enum logic [1:0] {
    FLG_HOLD,
    FLG_SET,
    FLG_CLR,
    FLG_WARM
  } flag_op_e;
endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] d_in;
    if (g == 0) begin : g_first
      assign d_in = d_i;
    end else begin : g_next
      assign d_in = stg_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= '0;
      else         stg_q[g] <= d_in;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ioc_compare.sv
module ioc_compare #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic             port_acc_i,
  input  logic             en_we_i,
  input  logic [WIDTH-1:0] en_wdata_i,
  output logic             mism_o
);
  localparam int unsigned INIT_LAST = STAGES + 1;
  localparam int unsigned CW        = $clog2(INIT_LAST + 1);

  logic [CW-1:0]    init_cnt_q;
  logic             init_busy;
  logic [WIDTH-1:0] snap_q;
  logic [WIDTH-1:0] en_q;
  logic [WIDTH-1:0] diff;

  // snapshot keeps tracking the synchronizer until its reset zeros have flushed
  assign init_busy = (init_cnt_q != CW'(INIT_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        init_cnt_q <= '0;
    else if (init_busy) init_cnt_q <= init_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      snap_q <= '0;
    else if (init_busy || port_acc_i) snap_q <= sync_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  assign diff   = (sync_i ^ snap_q) & en_q;
  assign mism_o = !init_busy && (|diff);

  p_snap_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_acc_i |=> snap_q == $past(sync_i));
  p_snap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_acc_i && !init_busy) |=> $stable(snap_q));
  p_en_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> en_q == $past(en_wdata_i));
  p_en_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_q));
  p_disarmed_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !mism_o);
endmodule

// File: rtl/ioc_flag.sv
module ioc_flag
  import ioc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic warm_rst_i,
  input  logic mism_i,
  input  logic flag_clr_i,
  output logic flag_o
);
  flag_op_e op;
  logic     flag_q;

  always_comb begin
    if (warm_rst_i)      op = FLG_WARM;
    else if (mism_i)     op = FLG_SET;
    else if (flag_clr_i) op = FLG_CLR;
    else                 op = FLG_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else begin
      unique case (op)
        FLG_SET:            flag_q <= 1'b1;
        FLG_CLR, FLG_WARM:  flag_q <= 1'b0;
        default:            flag_q <= flag_q;
      endcase
    end
  end

  assign flag_o = flag_q;

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mism_i && !warm_rst_i) |=> flag_q);
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr_i && !warm_rst_i) |=> flag_q);
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !mism_i) |=> !flag_q);
  p_warm_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> !flag_q);
  p_no_spurious_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !mism_i) |=> !flag_q);
endmodule

// File: rtl/ioc_detect.sv
module ioc_detect #(
  parameter int unsigned WIDTH  = ioc_pkg::DEF_WIDTH,
  parameter int unsigned STAGES = ioc_pkg::DEF_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warm_rst_i,
  input  logic [WIDTH-1:0] pins_i,
  input  logic             port_acc_i,
  input  logic             en_we_i,
  input  logic [WIDTH-1:0] en_wdata_i,
  input  logic             flag_clr_i,
  output logic             flag_o,
  output logic             wake_o
);
  logic [WIDTH-1:0] pins_sync;
  logic             mism;

  ioc_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (pins_sync)
  );

  ioc_compare #(.WIDTH(WIDTH), .STAGES(STAGES)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (pins_sync),
    .port_acc_i (port_acc_i),
    .en_we_i    (en_we_i),
    .en_wdata_i (en_wdata_i),
    .mism_o     (mism)
  );

  ioc_flag u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .warm_rst_i (warm_rst_i),
    .mism_i     (mism),
    .flag_clr_i (flag_clr_i),
    .flag_o     (flag_o)
  );

  assign wake_o = flag_o;

  p_reset_low_r1: assert property (@(posedge clk_i) !rst_ni |-> !flag_o);
endmodule

// File: tb/ioc_detect_bench.sv
module ioc_detect_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         warm_rst_i = 1'b0;
  logic [W-1:0] pins_i = '0;
  logic         port_acc_i = 1'b0;
  logic         en_we_i = 1'b0;
  logic [W-1:0] en_wdata_i = '0;
  logic         flag_clr_i = 1'b0;
  logic         flag_o, wake_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  ioc_detect #(.WIDTH(W), .STAGES(2)) u_ioc_detect (
    .clk_i(clk), .rst_ni(rst_ni), .warm_rst_i(warm_rst_i), .pins_i(pins_i),
    .port_acc_i(port_acc_i), .en_we_i(en_we_i), .en_wdata_i(en_wdata_i),
    .flag_clr_i(flag_clr_i), .flag_o(flag_o), .wake_o(wake_o)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic check(input logic got, input logic exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: flag got=%0b exp=%0b", req, got, exp);
    end
    total++;
    if (wake_o !== got) begin
      bad++;
      $display("FAIL R10 (%s): wake got=%0b exp=%0b", req, wake_o, got);
    end
  endtask

  task automatic access_pulse();
    port_acc_i = 1'b1; tick(1); port_acc_i = 1'b0;
  endtask

  task automatic clear_pulse();
    flag_clr_i = 1'b1; tick(1); flag_clr_i = 1'b0;
  endtask

  task automatic warm_pulse();
    warm_rst_i = 1'b1; tick(1); warm_rst_i = 1'b0;
  endtask

  task automatic write_en(input logic [W-1:0] m);
    en_wdata_i = m; en_we_i = 1'b1; tick(1); en_we_i = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pins_i = 8'hA5;
    tick(3);
    check(flag_o, 1'b0, "R1 in reset");
    rst_ni = 1'b1;
    tick(6);
    pins_i = 8'h5A;
    tick(4);
    check(flag_o, 1'b0, "R1 unarmed after reset");
    pins_i = 8'hA5;
    tick(4);
    write_en(8'hFF);               // R11
    tick(2);
    check(flag_o, 1'b0, "R2 snapshot from pins");

    pins_i = 8'hA4;
    tick(2);
    check(flag_o, 1'b0, "R3 not yet after two edges");
    tick(1);
    check(flag_o, 1'b1, "R3 set after three edges");

    clear_pulse();
    check(flag_o, 1'b1, "R7 set beats clear");

    warm_pulse();
    check(flag_o, 1'b0, "R9 warm clears flag");
    tick(1);
    check(flag_o, 1'b1, "R9 snapshot and mask kept");

    access_pulse();
    check(flag_o, 1'b1, "R6 sticky after access");
    tick(2);
    check(flag_o, 1'b1, "R6 sticky holds");
    clear_pulse();
    check(flag_o, 1'b0, "R5 access ended mismatch");
    tick(3);
    check(flag_o, 1'b0, "R5 stays clear");

    pins_i = 8'hA5;
    tick(2);
    port_acc_i = 1'b1;
    tick(1);
    port_acc_i = 1'b0;
    check(flag_o, 1'b1, "R8 change with access");
    clear_pulse();
    check(flag_o, 1'b0, "R8 snapshot took new value");

    warm_pulse();
    tick(3);
    check(flag_o, 1'b0, "R9 no mismatch stays clear");

    // exhaustive mask x single-pin sweep, base pins all zero
    pins_i = '0;
    tick(3);
    access_pulse();
    clear_pulse();
    for (int m = 0; m < 256; m++) begin
      write_en(W'(m));
      for (int b = 0; b < W; b++) begin
        pins_i = W'(1) << b;
        tick(3);
        if (m[b]) check(flag_o, 1'b1, "R3 armed pin sweep");
        else      check(flag_o, 1'b0, "R4 disarmed pin sweep");
        pins_i = '0;
        tick(3);
        access_pulse();
        clear_pulse();
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule